// File: doc/BRIEF.md
# Serial Character Engine with Address-Selected Chip Select

This block moves one character at a time over a four-wire serial link. As master it makes the serial clock from the system clock and drives a single chip-select line. As slave it shifts on a serial clock that an outside master supplies. One control bit picks the role. The character length is set in software from 1 to 16 bits. Data goes out most significant bit first. The serial clock idles low, outgoing data changes on the falling edge, and incoming data is sampled on the rising edge.

Software starts a character by writing the transmit word to one of two data addresses. Both addresses send the same bits. One leaves chip select high. The other pulls chip select low for the whole character. This lets each character choose its own framing with no extra control write. When the last bit has shifted, the received bits go into a receive buffer, right-justified. A completion flag is set, and an interrupt is raised if it is enabled. Reading the buffer clears the flag. A status bit records a completion that arrives while the flag is still set.

Top module: `spi_char_engine`

## Requirements
- R1: The control field at bits [7:4] of address 0 holds the character length minus one (1 to 16 bits). A character ends after exactly that many serial clock cycles.
- R2: At the end of a character, the received bits are stored right-justified in the receive buffer (address 3). All bits above the character length read as zero.
- R3: Status bit 0 (address 4) becomes 1 at the end of every character. Reading address 3 clears it. If a completion and a read of address 3 fall in the same cycle, the read returns the previous buffer, the flag stays 1 and the buffer takes the new character.
- R4: The interrupt output equals the completion flag ANDed with control bit 1.
- R5: In master mode, a write to address 2 drives chip select low from the cycle after the write until the cycle the character ends. Chip select is high whenever no character is in progress.
- R6: In master mode, a write to address 1 sends the character with chip select held high throughout.
- R7: In master mode (control bit 0 = 1), the serial clock period is 2*(P+1) system clocks, where P is control bits [15:8]. The clock idles low. The output word goes out most significant bit first, and input bits are sampled on the rising edges.
- R8: In slave mode (control bit 0 = 0), the block clocks on the external serial clock through a two-flop synchronizer. It shifts the loaded word out most significant bit first and shifts input bits in. It drives no serial clock and no chip select.
- R9: Status bit 1 is set when a character ends while the completion flag is still 1 and the buffer is not being read in that cycle. Reading address 4 clears it.
- R10: Status bit 2 (busy) is 1 from an accepted data write until the character ends. While busy, writes to addresses 0, 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; reads of addresses 3 and 4 have side effects |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| csn_o | output | 1 | Active-low chip select |
| dout_o | output | 1 | Serial data out (to the slave as master, to the master as slave) |
| sclk_i | input | 1 | External serial clock used in slave mode |
| din_i | input | 1 | Serial data in |

## Verification
The end of a character and a software read of the receive buffer can fall in the same system clock. Here the flag set and the clear-on-read compete, as does the overrun decision. The bench predicts the edge exactly: an accepted master write finishes 2*L*(P+1) clocks later. It places the read strobe on that edge. It then checks three things: the read returned the older character, the flag is still set with no overrun, and the buffer now holds the new character. Back-to-back completions with no read in between test the overrun side separately.

// File: rtl/spi_eng_pkg.sv
// Package: register addresses and field positions shared by the engine
// and its bench-facing register block. Assumes a 3-bit register address.
package spi_eng_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_TX_PLAIN = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TX_FRAME = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_RXBUF    = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 3'd4;

    localparam int CTRL_MASTER_BIT = 0;
    localparam int CTRL_IRQEN_BIT  = 1;
    localparam int CTRL_LEN_LSB    = 4;
    localparam int CTRL_PRE_LSB    = 8;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;
    localparam int STAT_BUSY_BIT = 2;
endpackage

// File: rtl/spi_edge_sync.sv
// Module: spi_edge_sync
// Brings the external serial clock and data into the system clock domain
// through STAGES flops and emits one-cycle rise/fall pulses. The data
// output is aligned with the clock stage used for edge detection.
// Assumes STAGES >= 2 and a system clock at least 4x the serial clock.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic din_in,
    output logic rise,
    output logic fall,
    output logic din_sync
);
    logic [STAGES:0]   sclk_pipe;
    logic [STAGES-1:0] din_pipe;

    // Shift both inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            din_pipe  <= '0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk_in};
            din_pipe  <= {din_pipe[STAGES-2:0], din_in};
        end
    end

    // Edge pulses compare the last synchronized stage with one older copy.
    always_comb begin
        rise     = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
        fall     = ~sclk_pipe[STAGES-1] & sclk_pipe[STAGES];
        din_sync = din_pipe[STAGES-1];
    end
endmodule

// File: rtl/spi_half_timer.sv
// Module: spi_half_timer
// Divides the system clock for master mode: tick pulses once every
// presc+1 clocks while run is high, marking each serial clock half period.
// The counter is held at zero while run is low.
module spi_half_timer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // A half period is reached when the count equals the prescale value.
    always_comb tick = run && (cnt_q == presc);

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Module: spi_shift_core
// One shift register carries the outgoing word and collects the incoming
// one. Input is sampled on the rising edge and shifted in on the falling
// edge, MSB first. done pulses on the falling edge of the last bit, and
// rx_word carries the right-justified result in that cycle.
// Assumes len_m1 does not change while a character is in flight.
module spi_shift_core #(
    parameter int DW    = 16,
    parameter int LEN_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             load,
    input  logic [DW-1:0]    load_word,
    input  logic             load_frame,
    input  logic             m_tick,
    input  logic             s_rise,
    input  logic             s_fall,
    input  logic             din_raw,
    input  logic             din_sync,
    output logic             sclk_o,
    output logic             csn_o,
    output logic             dout_o,
    output logic             done,
    output logic [DW-1:0]    rx_word
);
    localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(DW - 1);

    logic             sclk_q;
    logic             csn_q;
    logic             samp_q;
    logic [DW-1:0]    sh_q;
    logic [LEN_W-1:0] bitcnt_q;
    logic [DW-1:0]    mask;
    logic [DW-1:0]    nxt;
    logic             rise_ev;
    logic             fall_ev;

    // Pick edge events from the internal divider or the synchronized clock.
    always_comb begin
        mask    = {DW{1'b1}} >> (TOP_IDX - len_m1);
        rise_ev = master ? (m_tick & ~sclk_q) : s_rise;
        fall_ev = master ? (m_tick & sclk_q) : s_fall;
        nxt     = {sh_q[DW-2:0], samp_q};
        done    = fall_ev && (bitcnt_q == len_m1);
        rx_word = nxt & mask;
        sclk_o  = sclk_q;
        csn_o   = csn_q;
        dout_o  = sh_q[len_m1];
    end

    // Load, sample, shift and frame one character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            csn_q    <= 1'b1;
            samp_q   <= 1'b0;
            sh_q     <= '0;
            bitcnt_q <= '0;
        end else if (load) begin
            sh_q     <= load_word & mask;
            bitcnt_q <= '0;
            sclk_q   <= 1'b0;
            csn_q    <= ~(load_frame & master);
        end else begin
            if (master && m_tick) sclk_q <= ~sclk_q;
            if (rise_ev) samp_q <= master ? din_raw : din_sync;
            if (fall_ev) begin
                if (done) begin
                    sh_q     <= '0;
                    bitcnt_q <= '0;
                    csn_q    <= 1'b1;
                end else begin
                    sh_q     <= nxt;
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end

    // R5: chip select is only ever driven low in master mode.
    a_r5_csn_only_master: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_o |-> master);

    // R8: no serial clock leaves the block in slave mode.
    a_r8_sclk_quiet_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> !sclk_o);
endmodule

// File: rtl/spi_char_engine.sv
// Module: spi_char_engine (top)
// Register block around the shift core. The data address written picks the
// chip-select framing for that character. It holds the receive buffer,
// completion, overrun and busy state, and drives the interrupt.
// Assumes bus strobes last one cycle and 8 + PRE_W <= DW.
module spi_char_engine
    import spi_eng_pkg::*;
#(
    parameter int DW          = 16,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o,
    output logic              sclk_o,
    output logic              csn_o,
    output logic              dout_o,
    input  logic              sclk_i,
    input  logic              din_i
);
    localparam int LEN_W = $clog2(DW);

    logic             master_q;
    logic             irqen_q;
    logic [LEN_W-1:0] len_q;
    logic [PRE_W-1:0] pre_q;
    logic [DW-1:0]    rxbuf_q;
    logic             done_q;
    logic             ovr_q;
    logic             busy_q;

    logic             ctrl_wr;
    logic             load;
    logic             load_frame;
    logic             rd_rx;
    logic             rd_st;
    logic             m_tick;
    logic             s_rise;
    logic             s_fall;
    logic             din_sync;
    logic             core_done;
    logic [DW-1:0]    rx_word;

    // Decode bus strobes; control and data writes are dropped while busy.
    always_comb begin
        ctrl_wr    = bus_wr && (bus_addr == ADDR_CTRL) && !busy_q;
        load       = bus_wr && !busy_q &&
                     ((bus_addr == ADDR_TX_PLAIN) || (bus_addr == ADDR_TX_FRAME));
        load_frame = (bus_addr == ADDR_TX_FRAME);
        rd_rx      = bus_rd && (bus_addr == ADDR_RXBUF);
        rd_st      = bus_rd && (bus_addr == ADDR_STATUS);
    end

    spi_half_timer #(.PRE_W(PRE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q && master_q),
        .presc (pre_q),
        .tick  (m_tick)
    );

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_i),
        .din_in   (din_i),
        .rise     (s_rise),
        .fall     (s_fall),
        .din_sync (din_sync)
    );

    spi_shift_core #(.DW(DW), .LEN_W(LEN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (master_q),
        .len_m1     (len_q),
        .load       (load),
        .load_word  (bus_wdata),
        .load_frame (load_frame),
        .m_tick     (m_tick),
        .s_rise     (s_rise),
        .s_fall     (s_fall),
        .din_raw    (din_i),
        .din_sync   (din_sync),
        .sclk_o     (sclk_o),
        .csn_o      (csn_o),
        .dout_o     (dout_o),
        .done       (core_done),
        .rx_word    (rx_word)
    );

    // Control register: role, interrupt enable, length and prescale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            irqen_q  <= 1'b0;
            len_q    <= '0;
            pre_q    <= '0;
        end else if (ctrl_wr) begin
            master_q <= bus_wdata[CTRL_MASTER_BIT];
            irqen_q  <= bus_wdata[CTRL_IRQEN_BIT];
            len_q    <= bus_wdata[CTRL_LEN_LSB +: LEN_W];
            pre_q    <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
        end
    end

    // Receive buffer, completion flag, overrun and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            if (core_done) rxbuf_q <= rx_word;
            if (core_done)  done_q <= 1'b1;
            else if (rd_rx) done_q <= 1'b0;
            if (core_done && done_q && !rd_rx) ovr_q <= 1'b1;
            else if (rd_st)                    ovr_q <= 1'b0;
            if (load)           busy_q <= 1'b1;
            else if (core_done) busy_q <= 1'b0;
        end
    end

    // Read mux and interrupt output.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_MASTER_BIT]            = master_q;
                bus_rdata[CTRL_IRQEN_BIT]             = irqen_q;
                bus_rdata[CTRL_LEN_LSB +: LEN_W]      = len_q;
                bus_rdata[CTRL_PRE_LSB +: PRE_W]      = pre_q;
            end
            ADDR_RXBUF: bus_rdata = rxbuf_q;
            ADDR_STATUS: begin
                bus_rdata[STAT_DONE_BIT] = done_q;
                bus_rdata[STAT_OVR_BIT]  = ovr_q;
                bus_rdata[STAT_BUSY_BIT] = busy_q;
            end
            default: bus_rdata = '0;
        endcase
        irq_o = done_q & irqen_q;
    end

    // R3: a completing character always leaves the flag set.
    a_r3_done_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_q);

    // R9: overrun can only appear while a completion was already pending.
    a_r9_ovr_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(done_q));

    // R10: busy only drops on a character completion.
    a_r10_busy_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(core_done));

    // R5, R7: with no character in flight, chip select is high and clock low.
    a_r5_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (csn_o && !sclk_o));

    // R4: the interrupt rises only after a completion or a control write.
    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(core_done) || $past(ctrl_wr)));
endmodule

// File: tb/spi_char_engine_bench.sv
// Bench: directed corner cases plus seeded random master and slave
// characters, with expected values computed by bench functions.
module spi_char_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, sclk_o, csn_o, dout_o;
    logic        sclk_i = 1'b0;
    logic        din_i;

    logic        slave_phase = 1'b0;
    logic        din_s = 1'b0;
    logic        din_m = 1'b0;
    assign din_i = slave_phase ? din_s : din_m;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    spi_char_engine u_spi_char_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sclk_o(sclk_o), .csn_o(csn_o), .dout_o(dout_o),
        .sclk_i(sclk_i), .din_i(din_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // Device model used while the engine is master.
    logic [15:0] pat = '0;
    int          plen = 1;
    int          nfall = 0;
    logic [15:0] cap = '0;
    int          nrise = 0;
    logic        cs_lo = 1'b0, cs_hi = 1'b0;
    int          t1 = 0, t2 = 0;

    always @(posedge sclk_o) begin
        cap = {cap[14:0], dout_o};
        if (nrise == 0) t1 = cyc;
        if (nrise == 1) t2 = cyc;
        nrise++;
        if (csn_o) cs_hi = 1'b1; else cs_lo = 1'b1;
    end

    always @(negedge sclk_o) begin
        nfall++;
        if (nfall < plen) din_m = pat[plen-1-nfall];
    end

    function automatic logic [15:0] lmask(int len);
        return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
    endfunction

    function automatic logic [15:0] ctrl_word(bit m, bit ie, int len, int p);
        logic [15:0] w;
        w = '0;
        w[0] = m;
        w[1] = ie;
        w[7:4] = 4'(len - 1);
        w[15:8] = 8'(p);
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic m_start(int len, int p, bit framed, bit ie,
                           logic [15:0] txd, logic [15:0] rxp);
        bus_write(3'd0, ctrl_word(1'b1, ie, len, p));
        pat = rxp; plen = len; nfall = 0; din_m = rxp[len-1];
        cap = '0; nrise = 0; cs_lo = 1'b0; cs_hi = 1'b0;
        bus_write(framed ? 3'd2 : 3'd1, txd);
        check(framed ? "R5 csn low after framed write" : "R6 csn high after plain write",
              32'(csn_o), 32'(!framed));
    endtask

    task automatic m_finish(int len, int p, bit framed, bit ie,
                            logic [15:0] txd, logic [15:0] rxp, bit readback);
        logic [15:0] d;
        repeat (2*len*(p+1) + 2) @(negedge clk);
        check("R1 serial clock count", 32'(nrise), 32'(len));
        check("R7 MSB-first output word", 32'(cap & lmask(len)), 32'(txd & lmask(len)));
        if (len >= 2) check("R7 serial clock period", 32'(t2 - t1), 32'(2*(p+1)));
        check(framed ? "R5 csn framing" : "R6 csn never low",
              32'({cs_lo, cs_hi}), framed ? 32'h2 : 32'h1);
        check("R5 csn high after character", 32'(csn_o), 32'h1);
        check("R7 clock idles low", 32'(sclk_o), 32'h0);
        check("R4 interrupt after completion", 32'(irq_o), 32'(ie));
        if (readback) begin
            bus_read(3'd4, d);
            check("R3 done flag set", 32'(d & 16'h5), 32'h1);
            bus_read(3'd3, d);
            check("R2 right-justified receive", 32'(d), 32'(rxp & lmask(len)));
            bus_read(3'd4, d);
            check("R3 flag cleared by buffer read", 32'(d), 32'h0);
            check("R4 interrupt drops with flag", 32'(irq_o), 32'h0);
        end
    endtask

    task automatic m_xfer(int len, int p, bit framed, bit ie,
                          logic [15:0] txd, logic [15:0] rxp, bit readback);
        m_start(len, p, framed, ie, txd, rxp);
        m_finish(len, p, framed, ie, txd, rxp, readback);
    endtask

    task automatic s_xfer(int len, logic [15:0] txd, logic [15:0] rxp);
        logic [15:0] got;
        logic [15:0] d;
        bus_write(3'd0, ctrl_word(1'b0, 1'b0, len, 0));
        bus_write(3'd1, txd);
        slave_phase = 1'b1;
        got = '0;
        for (int i = 0; i < len; i++) begin
            din_s = rxp[len-1-i];
            repeat (8) @(negedge clk);
            got = {got[14:0], dout_o};
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        check("R8 slave output word", 32'(got & lmask(len)), 32'(txd & lmask(len)));
        check("R8 slave drives no clock or select", 32'({sclk_o, csn_o}), 32'h1);
        bus_read(3'd4, d);
        check("R3 slave completion flag", 32'(d), 32'h1);
        bus_read(3'd3, d);
        check("R2 R8 slave receive", 32'(d), 32'(rxp & lmask(len)));
        slave_phase = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] p1, p2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        bus_read(3'd4, d);
        check("R3 R9 R10 status after reset", 32'(d), 32'h0);
        bus_read(3'd3, d);
        check("R2 buffer after reset", 32'(d), 32'h0);
        check("R5 R7 lines after reset", 32'({csn_o, sclk_o, irq_o}), 32'h4);

        // Directed master characters including length extremes.
        m_xfer(8, 1, 1'b1, 1'b1, 16'h00A5, 16'h003C, 1'b1);
        m_xfer(1, 0, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1);
        m_xfer(16, 3, 1'b1, 1'b1, 16'hC35A, 16'h9E21, 1'b1);

        // R9: two completions without a buffer read.
        m_xfer(6, 0, 1'b0, 1'b0, 16'h0015, 16'h002B, 1'b0);
        m_xfer(6, 0, 1'b1, 1'b0, 16'h002A, 16'h0011, 1'b0);
        bus_read(3'd4, d);
        check("R9 overrun set", 32'(d), 32'h3);
        bus_read(3'd4, d);
        check("R9 overrun cleared by status read", 32'(d), 32'h1);
        bus_read(3'd3, d);
        check("R2 second character kept", 32'(d), 32'h0011);

        // R10: writes while busy are dropped.
        m_start(8, 2, 1'b0, 1'b0, 16'h0096, 16'h00F0);
        bus_read(3'd4, d);
        check("R10 busy during character", 32'(d), 32'h4);
        bus_write(3'd2, 16'h0069);
        bus_write(3'd0, ctrl_word(1'b0, 1'b1, 3, 0));
        m_finish(8, 2, 1'b0, 1'b0, 16'h0096, 16'h00F0, 1'b1);
        bus_read(3'd0, d);
        check("R10 control write ignored while busy", 32'(d), 32'(ctrl_word(1'b1, 1'b0, 8, 2)));

        // R3: completion and buffer read in the same cycle.
        p1 = 16'h00C7; p2 = 16'h0009;
        m_xfer(8, 0, 1'b0, 1'b0, 16'h0055, p1, 1'b0);
        m_start(4, 1, 1'b0, 1'b1, 16'h000B, p2);
        repeat (2*4*2 - 1) @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd3;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R3 colliding read returns older character", 32'(d), 32'(p1));
        bus_read(3'd4, d);
        check("R3 R9 flag kept without overrun", 32'(d), 32'h1);
        check("R4 interrupt held by kept flag", 32'(irq_o), 32'h1);
        bus_read(3'd3, d);
        check("R2 colliding character stored", 32'(d), 32'(p2));

        // Random master characters.
        for (int k = 0; k < 20; k++) begin
            int len, p;
            bit fr, ie;
            logic [15:0] tx, rx;
            len = 1 + int'($urandom_range(15));
            p   = int'($urandom_range(3));
            fr  = 1'($urandom_range(1));
            ie  = 1'($urandom_range(1));
            tx  = 16'($urandom);
            rx  = 16'($urandom);
            m_xfer(len, p, fr, ie, tx, rx, 1'b1);
        end

        // Slave characters: directed then random.
        s_xfer(8, 16'h00B4, 16'h0063);
        s_xfer(16, 16'hA1C3, 16'h5E0F);
        for (int k = 0; k < 4; k++) begin
            int len;
            len = 1 + int'($urandom_range(15));
            s_xfer(len, 16'($urandom), 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule